// File: doc/BRIEF.md
# Subframe User-Bit Capture Buffer

This block gathers the user bit that rides in every subframe of an already decoded AES3/S/PDIF receive stream and stores it in a pair of on-chip buffers used in ping-pong fashion. The upstream decoder presents one strobe per subframe. Each strobe carries a channel tag (A or B), a flag that marks the block start (the Z preamble) and the user bit. Filling is aligned to a block start, so bit 0 of every buffer is the first user bit of a block.

Configuration inputs choose the capture mode, the buffer length (384 or 768 bits) and the layout. The layout either keeps A and B bits interleaved in arrival order or places them in two separate halves. When a buffer completes, the block shows it on a word-wide read port and raises a sticky interrupt. The host clears the interrupt with an acknowledge pulse, which also hands the buffer back. A formatted mode can hold back the interrupt unless the block's ID (start) bit has changed.

Top module: `ubuf_capture`

## Requirements
- R1: `cfg_ub_mode` 2'b00 (off) and 2'b11 (reserved) capture nothing. With either code, a full block of strobes leaves `irq_full` low. Changing to one of these codes abandons a fill in progress.
- R2: Capture starts only on a strobe with `sf_zstart` high, and only when the target buffer is free. Strobes before that strobe are dropped. Buffer bit 0 is the user bit of the Z strobe.
- R3: With `cfg_split_ab`=0, bits are stored in arrival order at consecutive positions. Read word k bit j (`rd_data[j]`) is buffer bit k*8+j, where the word width is 8. `rd_data` is valid one clock after `rd_addr` is presented.
- R4: `cfg_len768`=0 selects 384 bits and 1 selects 768 bits. A buffer completes on exactly the strobe that writes its last bit. A second Z inside a 768-bit fill does not restart it.
- R5: With `cfg_split_ab`=1, A bits fill positions 0..N/2-1 and B bits fill N/2..N-1, each half in arrival order. The buffer completes only when both halves are full. Extra bits for a half that is already full are dropped.
- R6: `irq_full` rises on the clock edge that captures the completing strobe. It stays high until `rd_ack` and then falls on the next edge. While it is high, the read port shows the completed buffer. It is low after reset.
- R7: Mode 2'b01 fills the second buffer while the first waits for the host. On `rd_ack`, if the second buffer is already complete, it is exposed and `irq_full` stays high.
- R8: If both buffers are complete and unacknowledged, a Z strobe is dropped and `ovf` is set. `ovf` is sticky, clears on `rd_ack`, and is low after reset. The exposed data are unaffected.
- R9: Mode 2'b10 with `cfg_id_gate`=1 and `dat_cat`=1 discards a completed buffer, raising no interrupt and reusing the storage, when its bit 0 equals bit 0 of the previous buffer completed in mode 2'b10. The first such completion always interrupts. With `dat_cat`=0 every buffer interrupts.
- R10: Mode 2'b10 without ID gating captures and interrupts exactly as mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ub_mode | input | 2 | 00 off, 01 double buffer, 10 formatted, 11 reserved (off) |
| cfg_len768 | input | 1 | 0 selects 384 bits, 1 selects 768 bits |
| cfg_split_ab | input | 1 | 0 interleaved, 1 A/B halves |
| cfg_id_gate | input | 1 | Interrupt only on an ID bit change (formatted mode) |
| dat_cat | input | 1 | Upstream flag that the DAT category was detected |
| sf_stb | input | 1 | One-cycle strobe per decoded subframe |
| sf_is_b | input | 1 | Subframe belongs to channel B |
| sf_zstart | input | 1 | Subframe carried the block-start preamble |
| sf_ubit | input | 1 | User bit of the subframe |
| rd_addr | input | 7 | Word address into the exposed buffer |
| rd_ack | input | 1 | Host finished reading; clears interrupt and overflow |
| rd_data | output | 8 | Registered read word |
| irq_full | output | 1 | Sticky buffer-complete interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
`irq_full` and `ovf` change on the clock edge that captures the completing or dropped strobe. The bench drives every strobe for one cycle from a falling edge and samples the flags on the next falling edge, just after the capture. A read word is due one edge after its address, so the bench sets `rd_addr` on a falling edge and compares `rd_data` on the following one. An acknowledge acts on the edge it is held through and is judged on the falling edge after it. The check of "not yet complete" is made just before the final strobe of a buffer.

// File: rtl/ubuf_pkg.sv
package ubuf_pkg;
   typedef enum logic [1:0] {
      UB_OFF      = 2'b00,
      UB_PINGPONG = 2'b01,
      UB_FORMAT   = 2'b10,
      UB_RSVD     = 2'b11
   } ub_mode_e;

   function automatic logic ub_capture_on(input logic [1:0] m);
      return (m == UB_PINGPONG) || (m == UB_FORMAT);
   endfunction
endpackage

// File: rtl/ubuf_wr_ctrl.sv
module ubuf_wr_ctrl #(
   parameter int SIZE_S = 384,
   parameter int SIZE_L = 768,
   parameter int IDX_W  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             buf_free,
   input  logic             cfg_len768,
   input  logic             cfg_split_ab,
   input  logic             sf_stb,
   input  logic             sf_is_b,
   input  logic             sf_zstart,
   input  logic             sf_ubit,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             done,
   output logic             drop_z,
   output logic             first_bit
);
   localparam logic [IDX_W-1:0] LEN_S = IDX_W'(SIZE_S);
   localparam logic [IDX_W-1:0] LEN_L = IDX_W'(SIZE_L);
   localparam logic [IDX_W-1:0] ONE   = IDX_W'(1);

   logic             busy;
   logic [IDX_W-1:0] cnt, cnt_a, cnt_b;
   logic [IDX_W-1:0] len, half;
   logic             start_ok, take, last;

   assign len      = cfg_len768 ? LEN_L : LEN_S;
   assign half     = len >> 1;
   assign start_ok = !busy && sf_zstart && buf_free;
   assign take     = cap_en && sf_stb && (busy || start_ok);
   assign drop_z   = cap_en && sf_stb && sf_zstart && !busy && !buf_free;

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = '0;
      last   = 1'b0;
      if (take) begin
         if (cfg_split_ab) begin
            if (sf_is_b) begin
               if (cnt_b < half) begin
                  wr_en  = 1'b1;
                  wr_idx = half + cnt_b;
                  last   = (cnt_b == half - ONE) && (cnt_a == half);
               end
            end else if (cnt_a < half) begin
               wr_en  = 1'b1;
               wr_idx = cnt_a;
               last   = (cnt_a == half - ONE) && (cnt_b == half);
            end
         end else begin
            wr_en  = 1'b1;
            wr_idx = cnt;
            last   = (cnt == len - ONE);
         end
      end
   end

   assign done = wr_en && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt       <= '0;
         cnt_a     <= '0;
         cnt_b     <= '0;
         first_bit <= 1'b0;
      end else if (!cap_en || done) begin
         busy  <= 1'b0;
         cnt   <= '0;
         cnt_a <= '0;
         cnt_b <= '0;
      end else if (wr_en) begin
         busy <= 1'b1;
         if (!cfg_split_ab)  cnt   <= cnt + ONE;
         else if (sf_is_b)   cnt_b <= cnt_b + ONE;
         else                cnt_a <= cnt_a + ONE;
         if (wr_idx == '0) first_bit <= sf_ubit;
      end
   end

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !cap_en |=> !busy); // R1
   AST_DONE_REARMS: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R2
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (wr_idx < len)); // R4
   AST_WRITE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> buf_free); // R8
endmodule

// File: rtl/ubuf_bank.sv
module ubuf_bank #(
   parameter int MAXB   = 768,
   parameter int RD_W   = 8,
   parameter int IDX_W  = 10,
   parameter int RA_W   = 7,
   parameter bit RD_REG = 1'b1
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit,
   input  logic             rd_sel,
   input  logic [RA_W-1:0]  rd_addr,
   output logic [RD_W-1:0]  rd_data
);
   logic [IDX_W-1:0] base;
   logic [RD_W-1:0]  word [2];

   assign base = IDX_W'(rd_addr) * IDX_W'(RD_W);

   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [MAXB-1:0] bits;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_sel == 1'(g))) bits[wr_idx] <= wr_bit;
      end
      assign word[g] = bits[base +: RD_W];
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) rd_data <= word[rd_sel];
   end else begin : g_rd_comb
      assign rd_data = word[rd_sel];
   end
endmodule

// File: rtl/ubuf_pingpong.sv
module ubuf_pingpong (
   input  logic clk,
   input  logic rst_n,
   input  logic fmt_mode,
   input  logic id_gate,
   input  logic done,
   input  logic first_bit,
   input  logic drop_z,
   input  logic rd_ack,
   output logic wr_sel,
   output logic rd_sel,
   output logic buf_free,
   output logic irq,
   output logic ovf
);
   logic [1:0] full, full_n;
   logic       irq_n, rd_sel_n, wr_sel_n;
   logic       last_id, id_seen, keep, other;

   assign keep     = !(fmt_mode && id_gate && id_seen && (first_bit == last_id));
   assign other    = ~rd_sel;
   assign buf_free = !full[wr_sel];

   always_comb begin
      full_n   = full;
      irq_n    = irq;
      rd_sel_n = rd_sel;
      wr_sel_n = wr_sel;
      if (rd_ack && irq) begin
         full_n[rd_sel] = 1'b0;
         if (full_n[other]) rd_sel_n = other;
         else               irq_n    = 1'b0;
      end
      if (done && keep) begin
         full_n[wr_sel] = 1'b1;
         wr_sel_n       = ~wr_sel;
         if (!irq_n) begin
            irq_n    = 1'b1;
            rd_sel_n = wr_sel;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= '0;
         irq     <= 1'b0;
         rd_sel  <= 1'b0;
         wr_sel  <= 1'b0;
         ovf     <= 1'b0;
         last_id <= 1'b0;
         id_seen <= 1'b0;
      end else begin
         full   <= full_n;
         irq    <= irq_n;
         rd_sel <= rd_sel_n;
         wr_sel <= wr_sel_n;
         if (rd_ack)      ovf <= 1'b0;
         else if (drop_z) ovf <= 1'b1;
         if (done && fmt_mode) begin
            last_id <= first_bit;
            id_seen <= 1'b1;
         end
      end
   end

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq && !rd_ack) |=> irq); // R6
   AST_IRQ_BACKED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> full[rd_sel]); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !rd_ack) |=> ovf); // R8
   AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) drop_z |-> (full == 2'b11)); // R8
endmodule

// File: rtl/ubuf_capture.sv
module ubuf_capture #(
   parameter int SIZE_S = 384,
   parameter int SIZE_L = 768,
   parameter int RD_W   = 8,
   parameter bit RD_REG = 1'b1,
   localparam int IDX_W = $clog2(SIZE_L + 1),
   localparam int RA_W  = $clog2(SIZE_L / RD_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_ub_mode,
   input  logic            cfg_len768,
   input  logic            cfg_split_ab,
   input  logic            cfg_id_gate,
   input  logic            dat_cat,
   input  logic            sf_stb,
   input  logic            sf_is_b,
   input  logic            sf_zstart,
   input  logic            sf_ubit,
   input  logic [RA_W-1:0] rd_addr,
   input  logic            rd_ack,
   output logic [RD_W-1:0] rd_data,
   output logic            irq_full,
   output logic            ovf
);
   import ubuf_pkg::*;

   initial begin
      assert (SIZE_S > 0 && SIZE_L >= SIZE_S) else $error("size parameters out of order");
      assert (SIZE_S % (2 * RD_W) == 0 && SIZE_L % (2 * RD_W) == 0) else $error("sizes must hold whole words per half");
   end

   logic             cap_en, fmt_mode;
   logic             wr_en, done, drop_z, first_bit;
   logic [IDX_W-1:0] wr_idx;
   logic             wr_sel, rd_sel, buf_free;

   assign cap_en   = ub_capture_on(cfg_ub_mode);
   assign fmt_mode = (cfg_ub_mode == UB_FORMAT);

   ubuf_wr_ctrl #(.SIZE_S(SIZE_S), .SIZE_L(SIZE_L), .IDX_W(IDX_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .buf_free(buf_free),
      .cfg_len768(cfg_len768), .cfg_split_ab(cfg_split_ab),
      .sf_stb(sf_stb), .sf_is_b(sf_is_b), .sf_zstart(sf_zstart), .sf_ubit(sf_ubit),
      .wr_en(wr_en), .wr_idx(wr_idx), .done(done), .drop_z(drop_z), .first_bit(first_bit)
   );

   ubuf_pingpong u_pp (
      .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode), .id_gate(cfg_id_gate && dat_cat),
      .done(done), .first_bit(first_bit), .drop_z(drop_z), .rd_ack(rd_ack),
      .wr_sel(wr_sel), .rd_sel(rd_sel), .buf_free(buf_free), .irq(irq_full), .ovf(ovf)
   );

   ubuf_bank #(.MAXB(SIZE_L), .RD_W(RD_W), .IDX_W(IDX_W), .RA_W(RA_W), .RD_REG(RD_REG)) u_bank (
      .clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_bit(sf_ubit),
      .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: tb/ubuf_capture_tb.sv
module ubuf_capture_tb;
   localparam int CLK_P = 10;
   localparam int SZS   = 384;
   localparam int SZL   = 768;
   localparam int RDW   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_ub_mode = 2'b00;
   logic       cfg_len768 = 1'b0, cfg_split_ab = 1'b0, cfg_id_gate = 1'b0, dat_cat = 1'b0;
   logic       sf_stb = 1'b0, sf_is_b = 1'b0, sf_zstart = 1'b0, sf_ubit = 1'b0;
   logic [6:0] rd_addr = '0;
   logic       rd_ack = 1'b0;
   logic [7:0] rd_data;
   logic       irq_full, ovf;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;
   bit a_bits [SZS];
   bit b_bits [SZS];
   bit exp_buf [SZL];

   ubuf_capture u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_ub_mode(cfg_ub_mode), .cfg_len768(cfg_len768),
      .cfg_split_ab(cfg_split_ab), .cfg_id_gate(cfg_id_gate), .dat_cat(dat_cat),
      .sf_stb(sf_stb), .sf_is_b(sf_is_b), .sf_zstart(sf_zstart), .sf_ubit(sf_ubit),
      .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .irq_full(irq_full), .ovf(ovf)
   );

   always #(CLK_P / 2) clk = ~clk;

   function automatic int exp_pos(input bit split, input int len, input bit is_b, input int frame);
      if (split) return is_b ? (len / 2 + frame) : frame;
      return 2 * frame + (is_b ? 1 : 0);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic sub(input bit z, input bit isb, input bit u);
      @(negedge clk);
      sf_stb = 1'b1; sf_zstart = z; sf_is_b = isb; sf_ubit = u;
      @(negedge clk);
      sf_stb = 1'b0; sf_zstart = 1'b0;
      repeat ($urandom_range(0, 1)) @(negedge clk);
   endtask

   task automatic make_frames(input int n, input int first);
      for (int f = 0; f < n; f++) begin
         a_bits[f] = 1'($urandom);
         b_bits[f] = 1'($urandom);
      end
      if (first >= 0) a_bits[0] = 1'(first);
   endtask

   task automatic send_frames(input int lo, input int hi);
      for (int f = lo; f < hi; f++) begin
         sub((f % 192) == 0, 1'b0, a_bits[f]);
         sub(1'b0, 1'b1, b_bits[f]);
      end
   endtask

   task automatic build_exp(input bit split, input int len);
      for (int f = 0; f < len / 2; f++) begin
         exp_buf[exp_pos(split, len, 1'b0, f)] = a_bits[f];
         exp_buf[exp_pos(split, len, 1'b1, f)] = b_bits[f];
      end
   endtask

   task automatic read_cmp(input int len, input string req);
      for (int w = 0; w < len / RDW; w++) begin
         logic [7:0] e;
         for (int j = 0; j < RDW; j++) e[j] = exp_buf[w * RDW + j];
         @(negedge clk); rd_addr = 7'(w);
         @(negedge clk);
         chk(req, int'(rd_data), int'(e));
      end
   endtask

   task automatic ack();
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      int seed;
      seed = int'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk("R6 reset irq", int'(irq_full), 0);
      chk("R8 reset ovf", int'(ovf), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: off and reserved codes capture nothing
      cfg_ub_mode = 2'b00;
      make_frames(192, -1); send_frames(0, 192);
      chk("R1 mode00 no irq", int'(irq_full), 0);
      cfg_ub_mode = 2'b11;
      make_frames(192, -1); send_frames(0, 192);
      chk("R1 mode11 no irq", int'(irq_full), 0);

      // R2 R3 R4 R6: interleaved 384 with leading junk
      cfg_ub_mode = 2'b01;
      for (int k = 0; k < 5; k++) sub(1'b0, 1'(k % 2), 1'($urandom));
      chk("R2 junk ignored", int'(irq_full), 0);
      make_frames(192, -1);
      send_frames(0, 191);
      sub(1'b0, 1'b0, a_bits[191]);
      chk("R4 not full before last bit", int'(irq_full), 0);
      sub(1'b0, 1'b1, b_bits[191]);
      chk("R6 irq on completion", int'(irq_full), 1);
      build_exp(1'b0, SZS);
      read_cmp(SZS, "R3 interleaved data");
      chk("R6 irq sticky", int'(irq_full), 1);
      ack();
      chk("R6 irq cleared by ack", int'(irq_full), 0);

      // R5: split halves
      cfg_split_ab = 1'b1;
      make_frames(192, -1); send_frames(0, 192);
      chk("R5 split irq", int'(irq_full), 1);
      build_exp(1'b1, SZS);
      read_cmp(SZS, "R5 split data");
      ack();
      cfg_split_ab = 1'b0;

      // R4: 768-bit buffer spans two blocks
      cfg_len768 = 1'b1;
      make_frames(384, -1);
      send_frames(0, 192);
      chk("R4 768 not full after one block", int'(irq_full), 0);
      send_frames(192, 384);
      chk("R4 768 full after two blocks", int'(irq_full), 1);
      build_exp(1'b0, SZL);
      read_cmp(SZL, "R4 768 data");
      ack();
      cfg_len768 = 1'b0;

      // R7 R8: ping-pong and overflow
      make_frames(192, -1); send_frames(0, 192);
      build_exp(1'b0, SZS);
      read_cmp(SZS, "R7 first buffer exposed");
      make_frames(192, -1); send_frames(0, 192);
      chk("R7 irq held while second fills", int'(irq_full), 1);
      chk("R8 no ovf with one free", int'(ovf), 0);
      build_exp(1'b0, SZS);
      make_frames(192, -1); send_frames(0, 192);
      chk("R8 ovf on drop", int'(ovf), 1);
      ack();
      chk("R7 irq stays for second", int'(irq_full), 1);
      chk("R8 ovf cleared by ack", int'(ovf), 0);
      read_cmp(SZS, "R8 second buffer intact");
      ack();
      chk("R7 irq low after both read", int'(irq_full), 0);

      // R9: ID-change gating
      cfg_ub_mode = 2'b10; cfg_id_gate = 1'b1; dat_cat = 1'b1;
      make_frames(192, 1); send_frames(0, 192);
      chk("R9 first completion interrupts", int'(irq_full), 1);
      ack();
      make_frames(192, 1); send_frames(0, 192);
      chk("R9 same id no irq", int'(irq_full), 0);
      make_frames(192, 0); send_frames(0, 192);
      chk("R9 id change irq", int'(irq_full), 1);
      build_exp(1'b0, SZS);
      read_cmp(SZS, "R9 changed buffer data");
      ack();
      dat_cat = 1'b0;
      make_frames(192, 0); send_frames(0, 192);
      chk("R9 gate needs dat category", int'(irq_full), 1);
      ack();

      // R10: formatted mode without gating
      cfg_id_gate = 1'b0; dat_cat = 1'b1;
      make_frames(192, 0); send_frames(0, 192);
      chk("R10 format ungated irq", int'(irq_full), 1);
      build_exp(1'b0, SZS);
      read_cmp(SZS, "R10 format data");
      ack();
      chk("R10 ack clears", int'(irq_full), 0);

      summary();
      $finish;
   end
endmodule